// File: doc/BRIEF.md
# Short Frame Command Classifier

This block looks at one capture window of the reader-to-card line and decides whether it holds one of the two seven-bit short-frame commands that open the card-side protocol. The window has 32 demodulated samples. It starts at the start-of-frame slot and covers eight bit slots at four samples per slot. A sample set to 1 means a modulation pause was seen. Each slot is one of three symbols: a pause early in the slot, a pause in the middle of the slot, or no pause at all. The block classifies every slot and checks the start slot. It then decodes the seven data bits and checks that the zero-symbol choice follows the coding rule. Finally it compares the decoded value against the request and wake-up codes.

Surrounding logic pulses a strobe with the capture word. One clock later the block reports exactly one of three outcomes: request recognised, wake-up recognised, or abort. An abort tells the receive path to start over. On a match the block also gives the value of the last data bit, which the response timer uses to choose its delay. The end-of-frame slots lie after the window and are never examined.

Top module: `short_frame_classifier`

## Requirements
- R1: While rst_n is low, and right after it rises, res_valid, match_req, match_wake, abort and last_bit are 0 and cmd_code is 0.
- R2: A capture is taken only in a cycle where cap_strobe is 1. In the following cycle res_valid is 1 and exactly one of match_req, match_wake and abort is 1. In any cycle not preceded by a strobe, all four are 0.
- R3: Slot k takes cap_word[4k+3:4k], and within a slot bit 0 is the earliest sample. A slot is Z when it reads 4'b0001 (pause in sample 0), X when it reads 4'b0100 (pause in sample 2), and Y when it reads 4'b0000. Any other value is an invalid slot and leads to abort.
- R4: Slot 0 (start of frame) must be Z, or else the result is abort.
- R5: Data slots 1..7 carry data bits 0..6. X is a 1. A 0 must be Z when it directly follows the start slot or another 0, and must be Y when it follows a 1. Any violation leads to abort.
- R6: Data bits 0..6 = 0,1,0,1,0,1,0 (slots Z,Z,X,Y,X,Y,X,Y; word 32'h04040411) give match_req with cmd_code 2'd1.
- R7: Data bits 0..6 = 0,1,0,0,1,0,1 (slots Z,Z,X,Y,Z,X,Y,X; word 32'h40410411) give match_wake with cmd_code 2'd2.
- R8: A correctly coded frame with any other value gives abort with cmd_code 2'd0.
- R9: last_bit is data bit 6 on a match (0 for request, 1 for wake-up) and 0 on abort.
- R10: cmd_code and last_bit keep their value until the next strobe, and cap_word has no effect without a strobe.
- R11: Strobes in consecutive cycles each produce their own result, one cycle after their own strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_strobe | input | 1 | Single-cycle pulse: cap_word holds a capture |
| cap_word | input | 32 | Capture window, bit 0 earliest sample |
| res_valid | output | 1 | Result pulse, one cycle after the strobe |
| match_req | output | 1 | Request command recognised |
| match_wake | output | 1 | Wake-up command recognised |
| abort | output | 1 | Capture is not a recognised short frame |
| cmd_code | output | 2 | 0 none, 1 request, 2 wake-up; held |
| last_bit | output | 1 | Data bit 6 of the matched command; held |

## Verification
Two events can fall in the same cycle: presenting the result of one capture and accepting the next one. The bench provokes this by strobing a request word and a wake-up word on consecutive cycles. It expects the request outcome exactly in the cycle where the second strobe is sampled, and the wake-up outcome one cycle later, with no mixing of flags, code or last bit between the two. The same cycle overlap is repeated with an abort word following a match. This shows that the held code is overwritten in the right cycle.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    // Symbol found in one bit slot of the capture window
    typedef enum logic [1:0] {
        SYM_Y   = 2'd0,
        SYM_X   = 2'd1,
        SYM_Z   = 2'd2,
        SYM_BAD = 2'd3
    } sym_e;

    // Command outcome code presented on cmd_code
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_REQ  = 2'd1,
        CMD_WAKE = 2'd2
    } cmd_e;

    // Registered result state of the top module
    typedef struct packed {
        logic res_valid;
        logic match_req;
        logic match_wake;
        logic abort;
        cmd_e cmd;
        logic last_bit;
    } res_state_t;

endpackage

// File: rtl/sfc_symbol_slicer.sv
module sfc_symbol_slicer
    import sfc_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int OVS   = 4,
    parameter int X_POS = 2,
    parameter int Z_POS = 0
) (
    input  logic [SLOTS*OVS-1:0] word_i,
    output sym_e [SLOTS-1:0]     sym_o
);
    localparam logic [OVS-1:0] NIB_X = OVS'(1) << X_POS;
    localparam logic [OVS-1:0] NIB_Z = OVS'(1) << Z_POS;
    localparam logic [OVS-1:0] NIB_Y = '0;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [OVS-1:0] nib;
        assign nib = word_i[k*OVS +: OVS];

        always_comb begin
            if (nib == NIB_Z) begin
                sym_o[k] = SYM_Z;
            end else if (nib == NIB_X) begin
                sym_o[k] = SYM_X;
            end else if (nib == NIB_Y) begin
                sym_o[k] = SYM_Y;
            end else begin
                sym_o[k] = SYM_BAD;
            end
        end
    end

endmodule

// File: rtl/sfc_sequence_checker.sv
module sfc_sequence_checker
    import sfc_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int DBITS = SLOTS - 1
) (
    input  sym_e [SLOTS-1:0] sym_i,
    output logic [DBITS-1:0] bits_o,
    output logic             legal_o
);
    logic             ok;
    logic             prev_zero;
    logic [DBITS-1:0] bits;

    always_comb begin
        // Start slot must carry an early pause
        ok        = (sym_i[0] == SYM_Z);
        // The start slot is treated like a preceding zero
        prev_zero = 1'b1;
        bits      = '0;
        for (int k = 1; k < SLOTS; k++) begin
            unique case (sym_i[k])
                SYM_X: begin
                    bits[k-1] = 1'b1;
                    prev_zero = 1'b0;
                end
                SYM_Z: begin
                    if (!prev_zero) ok = 1'b0;
                    prev_zero = 1'b1;
                end
                SYM_Y: begin
                    if (prev_zero) ok = 1'b0;
                    prev_zero = 1'b1;
                end
                default: begin
                    ok        = 1'b0;
                    prev_zero = 1'b1;
                end
            endcase
        end
        bits_o  = bits;
        legal_o = ok;
    end

endmodule

// File: rtl/sfc_command_matcher.sv
module sfc_command_matcher
    import sfc_pkg::*;
#(
    parameter int               DBITS     = 7,
    parameter logic [DBITS-1:0] REQ_CODE  = 7'h2A,
    parameter logic [DBITS-1:0] WAKE_CODE = 7'h52
) (
    input  logic [DBITS-1:0] bits_i,
    input  logic             legal_i,
    output cmd_e             cmd_o,
    output logic             last_bit_o
);
    always_comb begin
        cmd_o      = CMD_NONE;
        last_bit_o = 1'b0;
        if (legal_i && bits_i == REQ_CODE) begin
            cmd_o      = CMD_REQ;
            last_bit_o = bits_i[DBITS-1];
        end else if (legal_i && bits_i == WAKE_CODE) begin
            cmd_o      = CMD_WAKE;
            last_bit_o = bits_i[DBITS-1];
        end
    end

endmodule

// File: rtl/short_frame_classifier.sv
module short_frame_classifier
    import sfc_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int OVS   = 4,
    parameter int X_POS = 2,
    parameter int Z_POS = 0,
    parameter logic [SLOTS-2:0] REQ_CODE  = 7'h2A,
    parameter logic [SLOTS-2:0] WAKE_CODE = 7'h52,
    localparam int WIN   = SLOTS * OVS,
    localparam int DBITS = SLOTS - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_strobe,
    input  logic [WIN-1:0] cap_word,
    output logic           res_valid,
    output logic           match_req,
    output logic           match_wake,
    output logic           abort,
    output logic [1:0]     cmd_code,
    output logic           last_bit
);
    sym_e [SLOTS-1:0] syms;
    logic [DBITS-1:0] data_bits;
    logic             frame_legal;
    cmd_e             cmd_found;
    logic             last_found;

    sfc_symbol_slicer #(
        .SLOTS (SLOTS),
        .OVS   (OVS),
        .X_POS (X_POS),
        .Z_POS (Z_POS)
    ) u_slicer (
        .word_i (cap_word),
        .sym_o  (syms)
    );

    sfc_sequence_checker #(
        .SLOTS (SLOTS)
    ) u_seq (
        .sym_i   (syms),
        .bits_o  (data_bits),
        .legal_o (frame_legal)
    );

    sfc_command_matcher #(
        .DBITS     (DBITS),
        .REQ_CODE  (REQ_CODE),
        .WAKE_CODE (WAKE_CODE)
    ) u_match (
        .bits_i     (data_bits),
        .legal_i    (frame_legal),
        .cmd_o      (cmd_found),
        .last_bit_o (last_found)
    );

    res_state_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.res_valid  = 1'b0;
        st_d.match_req  = 1'b0;
        st_d.match_wake = 1'b0;
        st_d.abort      = 1'b0;
        if (cap_strobe) begin
            st_d.res_valid  = 1'b1;
            st_d.match_req  = (cmd_found == CMD_REQ);
            st_d.match_wake = (cmd_found == CMD_WAKE);
            st_d.abort      = (cmd_found == CMD_NONE);
            st_d.cmd        = cmd_found;
            st_d.last_bit   = last_found;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{res_valid: 1'b0, match_req: 1'b0, match_wake: 1'b0,
                      abort: 1'b0, cmd: CMD_NONE, last_bit: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid  = st_q.res_valid;
    assign match_req  = st_q.match_req;
    assign match_wake = st_q.match_wake;
    assign abort      = st_q.abort;
    assign cmd_code   = st_q.cmd;
    assign last_bit   = st_q.last_bit;

endmodule

// File: rtl/short_frame_classifier_chk.sv
module short_frame_classifier_chk #(
    parameter int OVS   = 4,
    parameter int Z_POS = 0,
    parameter int WIN   = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cap_strobe,
    input logic [WIN-1:0] cap_word,
    input logic           res_valid,
    input logic           match_req,
    input logic           match_wake,
    input logic           abort,
    input logic [1:0]     cmd_code,
    input logic           last_bit
);
    localparam logic [OVS-1:0] NIB_Z = OVS'(1) << Z_POS;

    // R2
    result_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |=> res_valid);

    // R2
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_strobe |=> !res_valid && !match_req && !match_wake && !abort);

    // R2
    single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({match_req, match_wake, abort}) == 1);

    // R4
    bad_start_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_strobe && cap_word[OVS-1:0] != NIB_Z) |=> abort);

    // R9
    abort_clears_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (cmd_code == 2'd0) && !last_bit);

    // R10
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_strobe |=> $stable(cmd_code) && $stable(last_bit));

endmodule

bind short_frame_classifier short_frame_classifier_chk #(
    .OVS   (OVS),
    .Z_POS (Z_POS),
    .WIN   (WIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_strobe (cap_strobe),
    .cap_word   (cap_word),
    .res_valid  (res_valid),
    .match_req  (match_req),
    .match_wake (match_wake),
    .abort      (abort),
    .cmd_code   (cmd_code),
    .last_bit   (last_bit)
);

// File: tb/short_frame_classifier_tb.sv
module short_frame_classifier_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_strobe = 1'b0;
    logic [31:0] cap_word = '0;
    logic        res_valid, match_req, match_wake, abort, last_bit;
    logic [1:0]  cmd_code;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    short_frame_classifier u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_strobe (cap_strobe),
        .cap_word   (cap_word),
        .res_valid  (res_valid),
        .match_req  (match_req),
        .match_wake (match_wake),
        .abort      (abort),
        .cmd_code   (cmd_code),
        .last_bit   (last_bit)
    );

    localparam logic [31:0] W_REQ  = 32'h04040411;
    localparam logic [31:0] W_WAKE = 32'h40410411;

    typedef struct packed {
        logic [31:0] word;
        logic [1:0]  code;
        logic        last;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{W_REQ,          2'd1, 1'b0},  // R6 request
        '{W_WAKE,         2'd2, 1'b1},  // R7 wake-up
        '{32'h44444441,   2'd0, 1'b0},  // R8 all ones, legal, last bit 1 yet 0 out (R9)
        '{32'h11111111,   2'd0, 1'b0},  // R8 all zeros, legal
        '{32'h04040410,   2'd0, 1'b0},  // R4 start slot Y
        '{32'h04040414,   2'd0, 1'b0},  // R4 start slot X
        '{32'h04041411,   2'd0, 1'b0},  // R5 Z after a one
        '{32'h04040401,   2'd0, 1'b0},  // R5 Y right after start
        '{32'h04040413,   2'd0, 1'b0},  // R3 invalid slot value
        '{32'h04040811,   2'd0, 1'b0}   // R3 pause in wrong sample
    };

    function automatic logic [2:0] flags_for(input logic [1:0] code);
        case (code)
            2'd1:    return 3'b100;
            2'd2:    return 3'b010;
            default: return 3'b001;
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_result(input string req, input logic [1:0] code,
                                input logic last);
        logic [2:0] fl;
        fl = {match_req, match_wake, abort};
        check(res_valid == 1'b1, req, "res_valid", 32'(res_valid), 32'd1);
        check(fl == flags_for(code), req, "flags", 32'(fl), 32'(flags_for(code)));
        check(cmd_code == code, req, "cmd_code", 32'(cmd_code), 32'(code));
        check(last_bit == last, req, "last_bit", 32'(last_bit), 32'(last));
    endtask

    task automatic check_idle(input string req, input logic [1:0] code,
                              input logic last);
        logic [3:0] fl;
        fl = {res_valid, match_req, match_wake, abort};
        check(fl == 4'b0, req, "idle flags", 32'(fl), 32'd0);
        check(cmd_code == code, req, "held cmd_code", 32'(cmd_code), 32'(code));
        check(last_bit == last, req, "held last_bit", 32'(last_bit), 32'(last));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state during and after reset
        repeat (3) @(negedge clk);
        check_idle("R1", 2'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1", 2'd0, 1'b0);

        // Table walk: one strobe per vector, result one cycle later
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cap_strobe = 1'b1;
            cap_word   = VECS[i].word;
            @(negedge clk);
            cap_strobe = 1'b0;
            check_result($sformatf("R2/R6-R9 vec%0d", i), VECS[i].code, VECS[i].last);
        end

        // R10 held code after a wake-up; word change without strobe ignored
        @(negedge clk);
        cap_strobe = 1'b1;
        cap_word   = W_WAKE;
        @(negedge clk);
        cap_strobe = 1'b0;
        cap_word   = W_REQ;
        check_result("R7", 2'd2, 1'b1);
        repeat (4) begin
            @(negedge clk);
            cap_word = ~cap_word;
            check_idle("R10", 2'd2, 1'b1);
        end

        // R11 back-to-back strobes: request then wake-up then abort
        @(negedge clk);
        cap_strobe = 1'b1;
        cap_word   = W_REQ;
        @(negedge clk);
        cap_word   = W_WAKE;
        check_result("R11 first", 2'd1, 1'b0);
        @(negedge clk);
        cap_word   = 32'h11111111;
        check_result("R11 second", 2'd2, 1'b1);
        @(negedge clk);
        cap_strobe = 1'b0;
        check_result("R11 third", 2'd0, 1'b0);
        @(negedge clk);
        check_idle("R2", 2'd0, 1'b0);

        // R1 reset in mid-operation clears held values
        @(negedge clk);
        cap_strobe = 1'b1;
        cap_word   = W_WAKE;
        @(negedge clk);
        cap_strobe = 1'b0;
        check_result("R9", 2'd2, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 mid", 2'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after", 2'd0, 1'b0);

        finish_run();
    end

endmodule